// File: doc/BRIEF.md
# Integration Cycle Conversion Sequencer

This block paces the integration windows of a two-channel light-to-digital converter and moves the results out. It counts oscillator cycles for a window whose length is picked by a 2-bit select. During the window it adds up count-enable pulses from two external pulse sources, one accumulator per channel. When the window closes, both results are written into their holding registers on the same clock edge. A one-cycle completion pulse goes out, and the next window starts on the following cycle with no outside action.

Each channel can gain at most one count every two oscillator cycles. A fixed offset of two counts is subtracted from the total, and the result saturates at the top of the output width. Full scale is therefore half the window length minus two, or the register maximum if that is lower. When the select is 11, the window is timed by hand. Raising the manual bit opens the window. Lowering it closes the window and triggers the same transfer as a timed close. A power field other than 11 holds the counting logic cleared and leaves the holding registers untouched. The select register outside this block resets to 10.

Top module: `integ_sequencer`

## Requirements
- R1: The window lasts MULT_SHORT, MULT_MID or MULT_LONG times UNIT_CYCLES oscillator cycles for select values 00, 01 and 10.
- R2: A pulse is counted only on the even cycles of a window (cycle 0 is the first cycle), so at most one count is taken per two cycles. The stored result is the count minus 2, and it is 0 if the count is 2 or less.
- R3: A stored result saturates at 2^CNT_W-1.
- R4: Both holding registers load on the same edge, and that edge is the one after which cycleDone is high. The holding registers never change at any other time.
- R5: The next window starts on the cycle right after a transfer. Two completions in a row are exactly one window length apart.
- R6: With select 11, cycles on which manualBit is 1 form the window. The first cycle with manualBit back at 0 performs the transfer, and cycleDone is high on the cycle after it.
- R7: When select is not 11, manualBit has no effect on the window length or the result.
- R8: While powerField is not 11, no transfer occurs and the holding registers keep their values. When powerField returns to 11, a fresh window starts at cycle 0.
- R9: A change of select during a window throws that window away without a transfer. A new window then starts one cycle after the change.
- R10: cycleDone is never high for two cycles in a row.
- R11: After reset both holding registers are 0 and cycleDone is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| integSel | input | 2 | Window select: 00 short, 01 mid, 10 long, 11 manual |
| manualBit | input | 1 | Window open while 1 when select is 11 |
| powerField | input | 2 | Counting enabled only when 11 |
| ch0Pulse | input | 1 | Count-enable pulse, channel 0 |
| ch1Pulse | input | 1 | Count-enable pulse, channel 1 |
| data0 | output | CNT_W | Held result, channel 0 |
| data1 | output | CNT_W | Held result, channel 1 |
| cycleDone | output | 1 | One-cycle pulse following each transfer |

## Verification
The bench builds the block with UNIT_CYCLES = 4 and CNT_W = 8, and keeps the window multipliers and the offset at their defaults. The three timed windows are then 44, 324 and 1288 cycles long, so every select can run through many complete windows in a short run. With an 8-bit output, the long window runs far past 255 counts, which exercises saturation, while the short and mid windows stay below it. Manual windows of 30 and 3 cycles cover the offset floor and the stop-triggered transfer.

// File: rtl/integ_seq_pkg.sv
package integ_seq_pkg;
  typedef struct packed {
    logic clear;
    logic count;
    logic transfer;
  } seqStrobe_t;

  localparam logic [1:0] SEL_MANUAL = 2'b11;
  localparam logic [1:0] SEL_RESET  = 2'b10;
  localparam logic [1:0] PWR_ON     = 2'b11;
endpackage

// File: rtl/integ_seq_ctrl.sv
module integ_seq_ctrl
  import integ_seq_pkg::*;
#(
  parameter int UNIT_CYCLES = 918,
  parameter int MULT_SHORT  = 11,
  parameter int MULT_MID    = 81,
  parameter int MULT_LONG   = 322
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] integSel,
  input  logic       manualBit,
  input  logic [1:0] powerField,
  output seqStrobe_t strobe
);
  localparam int LEN_LONG_I = MULT_LONG * UNIT_CYCLES;
  localparam int CYC_W      = $clog2(LEN_LONG_I + 1);
  localparam logic [CYC_W-1:0] LEN_SHORT = CYC_W'(MULT_SHORT * UNIT_CYCLES);
  localparam logic [CYC_W-1:0] LEN_MID   = CYC_W'(MULT_MID * UNIT_CYCLES);
  localparam logic [CYC_W-1:0] LEN_LONG  = CYC_W'(LEN_LONG_I);

  logic [CYC_W-1:0] cycCnt;
  logic [CYC_W-1:0] winLen;
  logic [1:0]       selQ;
  logic             manRun;
  logic             pwrOn;
  logic             manualMode;
  logic             selChanged;
  logic             timedEnd;
  logic             manStop;

  assign pwrOn      = (powerField == PWR_ON);
  assign manualMode = (integSel == SEL_MANUAL);
  assign selChanged = (integSel != selQ);

  always_comb begin
    case (integSel)
      2'b00:   winLen = LEN_SHORT;
      2'b01:   winLen = LEN_MID;
      default: winLen = LEN_LONG;
    endcase
  end

  assign timedEnd = !manualMode && (cycCnt >= (winLen - 1'b1));
  assign manStop  = manualMode && manRun && !manualBit;

  always_comb begin
    strobe.clear    = !pwrOn || selChanged;
    strobe.count    = pwrOn && !selChanged && (manualMode ? manualBit : 1'b1);
    strobe.transfer = pwrOn && !selChanged && (timedEnd || manStop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= SEL_RESET;
      manRun <= 1'b0;
      cycCnt <= '0;
    end else begin
      selQ   <= integSel;
      manRun <= pwrOn && manualMode && manualBit && !selChanged;
      if (strobe.clear || strobe.transfer)
        cycCnt <= '0;
      else if (strobe.count && !manualMode)
        cycCnt <= cycCnt + 1'b1;
    end
  end
endmodule

// File: rtl/integ_chan_acc.sv
module integ_chan_acc
  import integ_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int OFFSET = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             phaseEven,
  input  logic             pulse,
  output logic [CNT_W-1:0] dataOut
);
  localparam int ACC_W = CNT_W + 1;
  localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'((2 ** CNT_W) - 1 + OFFSET);
  localparam logic [ACC_W-1:0] OFS     = ACC_W'(OFFSET);

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] accNext;
  logic [CNT_W-1:0] result;
  logic             accInc;

  assign accInc  = strobe.count && phaseEven && pulse;
  assign accNext = (accInc && (accQ < ACC_MAX)) ? accQ + 1'b1 : accQ;

  always_comb begin
    if (accNext > OFS) result = CNT_W'(accNext - OFS);
    else               result = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ    <= '0;
      dataOut <= '0;
    end else begin
      if (strobe.clear || strobe.transfer) accQ <= '0;
      else                                 accQ <= accNext;
      if (strobe.transfer) dataOut <= result;
    end
  end
endmodule

// File: rtl/integ_seq_datapath.sv
module integ_seq_datapath
  import integ_seq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16,
  parameter int OFFSET = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobe_t                   strobe,
  input  logic [NUM_CH-1:0]            pulseIn,
  output logic [NUM_CH-1:0][CNT_W-1:0] dataOut,
  output logic                         cycleDone
);
  logic phaseOdd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseOdd  <= 1'b0;
      cycleDone <= 1'b0;
    end else begin
      cycleDone <= strobe.transfer;
      if (strobe.clear || strobe.transfer) phaseOdd <= 1'b0;
      else if (strobe.count)               phaseOdd <= !phaseOdd;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    integ_chan_acc #(
      .CNT_W (CNT_W),
      .OFFSET(OFFSET)
    ) u_acc (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobe),
      .phaseEven(!phaseOdd),
      .pulse    (pulseIn[ch]),
      .dataOut  (dataOut[ch])
    );
  end
endmodule

// File: rtl/integ_sequencer.sv
module integ_sequencer
  import integ_seq_pkg::*;
#(
  parameter int UNIT_CYCLES = 918,
  parameter int MULT_SHORT  = 11,
  parameter int MULT_MID    = 81,
  parameter int MULT_LONG   = 322,
  parameter int CNT_W       = 16,
  parameter int OFFSET      = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       integSel,
  input  logic             manualBit,
  input  logic [1:0]       powerField,
  input  logic             ch0Pulse,
  input  logic             ch1Pulse,
  output logic [CNT_W-1:0] data0,
  output logic [CNT_W-1:0] data1,
  output logic             cycleDone
);
  localparam int NUM_CH = 2;

  seqStrobe_t                   strobe;
  logic [NUM_CH-1:0][CNT_W-1:0] dataAll;

  integ_seq_ctrl #(
    .UNIT_CYCLES(UNIT_CYCLES),
    .MULT_SHORT (MULT_SHORT),
    .MULT_MID   (MULT_MID),
    .MULT_LONG  (MULT_LONG)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .integSel  (integSel),
    .manualBit (manualBit),
    .powerField(powerField),
    .strobe    (strobe)
  );

  integ_seq_datapath #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W),
    .OFFSET(OFFSET)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pulseIn  ({ch1Pulse, ch0Pulse}),
    .dataOut  (dataAll),
    .cycleDone(cycleDone)
  );

  assign data0 = dataAll[0];
  assign data1 = dataAll[1];
endmodule

// File: rtl/integ_sequencer_chk.sv
module integ_sequencer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       integSel,
  input logic             manualBit,
  input logic [1:0]       powerField,
  input logic [CNT_W-1:0] data0,
  input logic [CNT_W-1:0] data1,
  input logic             cycleDone
);
  // R10
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  // R4
  p_data_with_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(data0) || !$stable(data1)) |-> cycleDone);

  // R8
  p_unpowered_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (powerField != 2'b11) |=> !cycleDone);

  // R8
  p_unpowered_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(powerField) != 2'b11) |-> ($stable(data0) && $stable(data1)));

  // R6
  p_manual_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (integSel == 2'b11 && $past(integSel) == 2'b11 && $past(integSel, 2) == 2'b11 &&
     powerField == 2'b11 && $past(powerField) == 2'b11 &&
     $past(manualBit) && !manualBit) |=> cycleDone);
endmodule

bind integ_sequencer integ_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .integSel  (integSel),
  .manualBit (manualBit),
  .powerField(powerField),
  .data0     (data0),
  .data1     (data1),
  .cycleDone (cycleDone)
);

// File: tb/integ_sequencer_tb.sv
module integ_sequencer_tb;
  localparam int CNT_W = 8;
  localparam int UNIT  = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       integSel = 2'b10;
  logic             manualBit = 1'b0;
  logic [1:0]       powerField = 2'b00;
  logic             ch0Pulse = 1'b0;
  logic             ch1Pulse = 1'b0;
  logic [CNT_W-1:0] data0;
  logic [CNT_W-1:0] data1;
  logic             cycleDone;

  int nChk  = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = !clk;

  integ_sequencer #(.UNIT_CYCLES(UNIT), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .integSel(integSel), .manualBit(manualBit),
    .powerField(powerField), .ch0Pulse(ch0Pulse), .ch1Pulse(ch1Pulse),
    .data0(data0), .data1(data1), .cycleDone(cycleDone)
  );

  // {sel, pattern0, pattern1, window length, expected0, expected1}
  // pattern: 0 none, 1 every cycle, 2 every 4th cycle, 3 every 16th cycle
  localparam logic [33:0] VEC [8] = '{
    {2'd0, 2'd1, 2'd0, 12'd44,   8'd20,  8'd0},
    {2'd0, 2'd2, 2'd3, 12'd44,   8'd9,   8'd1},
    {2'd1, 2'd1, 2'd2, 12'd324,  8'd160, 8'd79},
    {2'd1, 2'd3, 2'd0, 12'd324,  8'd19,  8'd0},
    {2'd2, 2'd1, 2'd3, 12'd1288, 8'd255, 8'd79},
    {2'd2, 2'd2, 2'd0, 12'd1288, 8'd255, 8'd0},
    {2'd2, 2'd3, 2'd3, 12'd1288, 8'd79,  8'd79},
    {2'd2, 2'd0, 2'd1, 12'd1288, 8'd0,   8'd255}
  };

  function automatic logic patBit(input logic [1:0] code, input int k);
    case (code)
      2'd0:    return 1'b0;
      2'd1:    return 1'b1;
      2'd2:    return (k % 4) == 0;
      default: return (k % 16) == 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive window cycles from index 0 until cycleDone is seen; returns cycles elapsed.
  task automatic measure(input logic [1:0] p0, input logic [1:0] p1,
                         input bit toggleMan, output int len);
    int k = 0;
    bit seen = 1'b0;
    while (!seen && k < 3000) begin
      ch0Pulse = patBit(p0, k);
      ch1Pulse = patBit(p1, k);
      if (toggleMan) manualBit = (k % 3) == 0;
      @(posedge clk);
      k++;
      @(negedge clk);
      seen = cycleDone;
    end
    len = k;
    manualBit = 1'b0;
  endtask

  task automatic powerUp(input logic [1:0] sel);
    powerField = 2'b00;
    integSel = sel;
    repeat (3) @(negedge clk);
    powerField = 2'b11;
  endtask

  initial begin
    int len;
    logic [CNT_W-1:0] held0;
    logic [CNT_W-1:0] held1;
    bit sawDone;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(data0 == 0, "R11 data0", data0, 0);
    check(data1 == 0, "R11 data1", data1, 0);
    check(cycleDone == 0, "R11 done", cycleDone, 0);

    // R1 R2 R3 R4 vector table
    for (int i = 0; i < 8; i++) begin
      powerUp(VEC[i][33:32]);
      measure(VEC[i][31:30], VEC[i][29:28], 1'b0, len);
      check(len == int'(VEC[i][27:16]), "R1 window length", len, int'(VEC[i][27:16]));
      check(data0 == VEC[i][15:8], "R2 R3 data0", data0, int'(VEC[i][15:8]));
      check(data1 == VEC[i][7:0], "R4 data1", data1, int'(VEC[i][7:0]));
    end

    // R5 automatic restart and R10 single-cycle done
    powerUp(2'b00);
    measure(2'd1, 2'd2, 1'b0, len);
    measure(2'd1, 2'd2, 1'b0, len);
    check(len == 44, "R5 restart spacing", len, 44);
    check(data0 == 20 && data1 == 9, "R5 second result", data0, 20);
    @(negedge clk);
    check(cycleDone == 0, "R10 done width", cycleDone, 0);

    // R7 manual bit toggling in timed mode
    powerUp(2'b00);
    measure(2'd1, 2'd0, 1'b1, len);
    check(len == 44, "R7 length unaffected", len, 44);
    check(data0 == 20, "R7 result unaffected", data0, 20);

    // R8 power off holds data and suppresses completion
    held0 = data0;
    held1 = data1;
    powerField = 2'b01;
    ch0Pulse = 1'b1;
    ch1Pulse = 1'b1;
    sawDone = 1'b0;
    for (int j = 0; j < 200; j++) begin
      @(negedge clk);
      if (cycleDone) sawDone = 1'b1;
    end
    check(!sawDone, "R8 no done while off", sawDone, 0);
    check(data0 == held0 && data1 == held1, "R8 data held", data0, held0);
    powerField = 2'b11;
    measure(2'd1, 2'd1, 1'b0, len);
    check(len == 44, "R8 fresh window after power up", len, 44);
    check(data1 == 20, "R8 result after power up", data1, 20);

    // R9 select change mid-window
    powerUp(2'b00);
    for (int j = 0; j < 10; j++) begin
      ch0Pulse = 1'b1;
      @(negedge clk);
    end
    integSel = 2'b01;
    measure(2'd1, 2'd0, 1'b0, len);
    check(len == 325, "R9 restart after select change", len, 325);
    check(data0 == 160, "R9 result", data0, 160);

    // R6 manual windows
    powerUp(2'b11);
    ch0Pulse = 1'b1;
    ch1Pulse = 1'b0;
    sawDone = 1'b0;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      if (cycleDone) sawDone = 1'b1;
    end
    check(!sawDone, "R6 idle with bit low", sawDone, 0);
    manualBit = 1'b1;
    repeat (30) @(negedge clk);
    check(cycleDone == 0, "R6 no done while open", cycleDone, 0);
    manualBit = 1'b0;
    @(negedge clk);
    check(cycleDone == 1, "R6 done after stop", cycleDone, 1);
    check(data0 == 13, "R6 manual result", data0, 13);
    manualBit = 1'b1;
    repeat (3) @(negedge clk);
    manualBit = 1'b0;
    @(negedge clk);
    check(cycleDone == 1, "R6 done after short window", cycleDone, 1);
    check(data0 == 0, "R2 offset floor", data0, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule